// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block governs the two reduced-power states of a small 16-bit microcontroller. The CPU decodes a guarded idle or power-down instruction and presents it together with both 16-bit halves of its encoding and a strobe marking the instruction's completion. The sequencer accepts the request only if the encoding is intact. It then moves between run, idle and power-down, and drives the enables for the CPU clock, the peripheral clocks and the watchdog.

Power-down is armed only when the non-maskable interrupt pin is low as the instruction completes. This lets a power-fail handler save its state and then stop the chip. Once in power-down, nothing except a low level on the external reset pin brings the chip back. Idle stops only the CPU and ends on a pending interrupt or on the NMI pin.

While the chip is in either low-power state, the sequencer also overrides the external-bus pins. The read and write strobes go inactive. The byte-high enable and the upper address byte keep what the last bus cycle left. The multiplexed data lines are released.

Top module: `lpm_sequencer`

## Requirements
- R1: After reset, `mode_o` is 2'b00 (run; 2'b01 is idle, 2'b10 is power-down, 2'b11 never appears). All three enables are high and `prot_fault_o` is low.
- R2: In run, a completion strobe with `req_pdown_i` high, an intact encoding and `nmi_ni` low sets `mode_o` to 2'b10 at the next clock edge. The CPU clock, peripheral clock and watchdog enables are then all low. A power-down request takes precedence over a simultaneous idle request.
- R3: A power-down instruction that completes while `nmi_ni` is high changes nothing: the mode stays 2'b00.
- R4: An encoding is intact when `op_second_i` equals the bitwise inverse of `op_first_i`. A completed request with a broken encoding is ignored and sets `prot_fault_o`, which stays high until reset.
- R5: A request with `instr_done_i` low never changes the mode.
- R6: Power-down is not left on `irq_pend_i` or on `nmi_ni`. A low level on `rst_ni` returns the block to run and clears `prot_fault_o`. Reset is asserted asynchronously and released through a two-stage synchronizer.
- R7: `ram_keep_o` is high in every mode, including during reset.
- R8: In run, an intact idle instruction at its completion strobe sets the mode to 2'b01 at the next edge. In idle, the CPU clock enable is low while the peripheral and watchdog enables stay high.
- R9: In idle, `irq_pend_i` high or `nmi_ni` low returns the mode to 2'b00 at the next edge, with the CPU clock enable high again.
- R10: Whenever the mode is not run, `wr_n_o` and `rd_n_o` are high and `ad_lo_oe_o` is low.
- R11: When the mode is not run, `bhe_n_o` and `ad_hi_o` show the values captured in the last run cycle that had `bus_cyc_i` high. `ad_hi_oe_o` equals `bus_mux8_i` in that case.
- R12: In run, all bus pin outputs follow their corresponding inputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | External active-low reset |
| instr_done_i | input | 1 | Completion strobe of the current instruction |
| req_idle_i | input | 1 | Decoded idle instruction |
| req_pdown_i | input | 1 | Decoded power-down instruction |
| op_first_i | input | 16 | First half of the guarded encoding |
| op_second_i | input | 16 | Second half of the guarded encoding |
| nmi_ni | input | 1 | NMI pin level, active low |
| irq_pend_i | input | 1 | An enabled interrupt is pending |
| bus_cyc_i | input | 1 | A bus access happens this cycle |
| bhe_n_i | input | 1 | Byte-high enable from the bus controller |
| addr_hi_i | input | 8 | High address byte of the current access |
| bus_mux8_i | input | 1 | Multiplexed bus with 8-bit data is configured |
| wr_n_i | input | 1 | Write strobe from the bus controller |
| rd_n_i | input | 1 | Read strobe from the bus controller |
| ad_hi_i | input | 8 | High address/data port value in run |
| ad_hi_oe_i | input | 1 | High address/data port drive enable in run |
| ad_lo_i | input | 8 | Low address/data port value in run |
| ad_lo_oe_i | input | 1 | Low address/data port drive enable in run |
| mode_o | output | 2 | Current mode |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| wdt_en_o | output | 1 | Watchdog enable |
| ram_keep_o | output | 1 | RAM contents preserved |
| prot_fault_o | output | 1 | Sticky broken-encoding flag |
| wr_n_o | output | 1 | Write strobe pin |
| rd_n_o | output | 1 | Read strobe pin |
| bhe_n_o | output | 1 | Byte-high enable pin |
| ad_hi_o | output | 8 | High address/data pin value |
| ad_hi_oe_o | output | 1 | High address/data pin drive enable |
| ad_lo_o | output | 8 | Low address/data pin value |
| ad_lo_oe_o | output | 1 | Low address/data pin drive enable |

## Verification
The mode register is the only stage between a request and its effect. A mode change is therefore visible one clock edge after the completion strobe or the wake condition is sampled. The enables and pin overrides decode that register directly, so they move on the same edge.

The bench drives inputs on the falling edge and checks on the next falling edge, which is exactly one rising edge later. Pass-through pins and the upper-port enable are checked within the same half cycle. Reset assertion is checked a nanosecond after the pin falls, since it acts without a clock. Reset release is awaited for the two synchronizer edges before any new stimulus.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    MODE_RUN   = 2'b00,
    MODE_IDLE  = 2'b01,
    MODE_PDOWN = 2'b10
  } lpm_mode_e;
endpackage

// File: rtl/lpm_rst_sync.sv
module lpm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  localparam int LAST = (STAGES < 2) ? 1 : STAGES - 1;

  logic [LAST:0] sync_q;
  logic [LAST:0] sync_d;

  always_comb begin
    sync_d = {sync_q[LAST-1:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_no = sync_q[LAST];
endmodule

// File: rtl/lpm_guard.sv
module lpm_guard #(
  parameter int HALF_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              done_i,
  input  logic              req_idle_i,
  input  logic              req_pdown_i,
  input  logic [HALF_W-1:0] op_first_i,
  input  logic [HALF_W-1:0] op_second_i,
  input  logic              nmi_ni,
  output logic              go_idle_o,
  output logic              go_pdown_o,
  output logic              fault_o
);
  logic intact;
  logic execute;
  logic fault_set;
  logic fault_q;
  logic fault_d;

  always_comb begin
    intact     = (op_second_i == ~op_first_i);
    execute    = run_i & done_i;
    go_pdown_o = execute & req_pdown_i & intact & ~nmi_ni;
    go_idle_o  = execute & req_idle_i & ~req_pdown_i & intact;
    fault_set  = execute & (req_idle_i | req_pdown_i) & ~intact;
    fault_d    = fault_q | fault_set;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fault_q <= 1'b0;
    else         fault_q <= fault_d;
  end

  assign fault_o = fault_q;
endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
  import lpm_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      go_idle_i,
  input  logic      go_pdown_i,
  input  logic      irq_pend_i,
  input  logic      nmi_ni,
  output lpm_mode_e mode_o,
  output logic      cpu_clk_en_o,
  output logic      per_clk_en_o,
  output logic      wdt_en_o
);
  lpm_mode_e mode_q;
  lpm_mode_e mode_d;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_RUN: begin
        if (go_pdown_i)     mode_d = MODE_PDOWN;
        else if (go_idle_i) mode_d = MODE_IDLE;
      end
      MODE_IDLE: begin
        if (irq_pend_i || !nmi_ni) mode_d = MODE_RUN;
      end
      MODE_PDOWN: mode_d = MODE_PDOWN;
      default:    mode_d = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_RUN;
    else         mode_q <= mode_d;
  end

  always_comb begin
    cpu_clk_en_o = (mode_q == MODE_RUN);
    per_clk_en_o = (mode_q != MODE_PDOWN);
    wdt_en_o     = (mode_q != MODE_PDOWN);
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/lpm_pin_ctrl.sv
module lpm_pin_ctrl #(
  parameter int AH_W = 8,
  parameter int AL_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            bus_cyc_i,
  input  logic            bhe_n_i,
  input  logic [AH_W-1:0] addr_hi_i,
  input  logic            bus_mux8_i,
  input  logic            wr_n_i,
  input  logic            rd_n_i,
  input  logic [AH_W-1:0] ad_hi_i,
  input  logic            ad_hi_oe_i,
  input  logic [AL_W-1:0] ad_lo_i,
  input  logic            ad_lo_oe_i,
  output logic            wr_n_o,
  output logic            rd_n_o,
  output logic            bhe_n_o,
  output logic [AH_W-1:0] ad_hi_o,
  output logic            ad_hi_oe_o,
  output logic [AL_W-1:0] ad_lo_o,
  output logic            ad_lo_oe_o
);
  logic            cap_en;
  logic            bhe_q;
  logic [AH_W-1:0] addr_q;

  assign cap_en = run_i & bus_cyc_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bhe_q  <= 1'b1;
      addr_q <= '0;
    end else if (cap_en) begin
      bhe_q  <= bhe_n_i;
      addr_q <= addr_hi_i;
    end
  end

  always_comb begin
    if (run_i) begin
      wr_n_o     = wr_n_i;
      rd_n_o     = rd_n_i;
      bhe_n_o    = bhe_n_i;
      ad_hi_o    = ad_hi_i;
      ad_hi_oe_o = ad_hi_oe_i;
      ad_lo_o    = ad_lo_i;
      ad_lo_oe_o = ad_lo_oe_i;
    end else begin
      wr_n_o     = 1'b1;
      rd_n_o     = 1'b1;
      bhe_n_o    = bhe_q;
      ad_hi_o    = addr_q;
      ad_hi_oe_o = bus_mux8_i;
      ad_lo_o    = '0;
      ad_lo_oe_o = 1'b0;
    end
  end
endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
  import lpm_pkg::*;
#(
  parameter int HALF_W      = 16,
  parameter int AH_W        = 8,
  parameter int AL_W        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              instr_done_i,
  input  logic              req_idle_i,
  input  logic              req_pdown_i,
  input  logic [HALF_W-1:0] op_first_i,
  input  logic [HALF_W-1:0] op_second_i,
  input  logic              nmi_ni,
  input  logic              irq_pend_i,
  input  logic              bus_cyc_i,
  input  logic              bhe_n_i,
  input  logic [AH_W-1:0]   addr_hi_i,
  input  logic              bus_mux8_i,
  input  logic              wr_n_i,
  input  logic              rd_n_i,
  input  logic [AH_W-1:0]   ad_hi_i,
  input  logic              ad_hi_oe_i,
  input  logic [AL_W-1:0]   ad_lo_i,
  input  logic              ad_lo_oe_i,
  output logic [1:0]        mode_o,
  output logic              cpu_clk_en_o,
  output logic              per_clk_en_o,
  output logic              wdt_en_o,
  output logic              ram_keep_o,
  output logic              prot_fault_o,
  output logic              wr_n_o,
  output logic              rd_n_o,
  output logic              bhe_n_o,
  output logic [AH_W-1:0]   ad_hi_o,
  output logic              ad_hi_oe_o,
  output logic [AL_W-1:0]   ad_lo_o,
  output logic              ad_lo_oe_o
);
  logic      rst_sync_n;
  logic      go_idle;
  logic      go_pdown;
  logic      in_run;
  lpm_mode_e mode;

  lpm_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  lpm_guard #(.HALF_W(HALF_W)) u_guard (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .run_i       (in_run),
    .done_i      (instr_done_i),
    .req_idle_i  (req_idle_i),
    .req_pdown_i (req_pdown_i),
    .op_first_i  (op_first_i),
    .op_second_i (op_second_i),
    .nmi_ni      (nmi_ni),
    .go_idle_o   (go_idle),
    .go_pdown_o  (go_pdown),
    .fault_o     (prot_fault_o)
  );

  lpm_mode_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_sync_n),
    .go_idle_i    (go_idle),
    .go_pdown_i   (go_pdown),
    .irq_pend_i   (irq_pend_i),
    .nmi_ni       (nmi_ni),
    .mode_o       (mode),
    .cpu_clk_en_o (cpu_clk_en_o),
    .per_clk_en_o (per_clk_en_o),
    .wdt_en_o     (wdt_en_o)
  );

  assign in_run     = (mode == MODE_RUN);
  assign mode_o     = mode;
  assign ram_keep_o = 1'b1;

  lpm_pin_ctrl #(.AH_W(AH_W), .AL_W(AL_W)) u_pins (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .run_i      (in_run),
    .bus_cyc_i  (bus_cyc_i),
    .bhe_n_i    (bhe_n_i),
    .addr_hi_i  (addr_hi_i),
    .bus_mux8_i (bus_mux8_i),
    .wr_n_i     (wr_n_i),
    .rd_n_i     (rd_n_i),
    .ad_hi_i    (ad_hi_i),
    .ad_hi_oe_i (ad_hi_oe_i),
    .ad_lo_i    (ad_lo_i),
    .ad_lo_oe_i (ad_lo_oe_i),
    .wr_n_o     (wr_n_o),
    .rd_n_o     (rd_n_o),
    .bhe_n_o    (bhe_n_o),
    .ad_hi_o    (ad_hi_o),
    .ad_hi_oe_o (ad_hi_oe_o),
    .ad_lo_o    (ad_lo_o),
    .ad_lo_oe_o (ad_lo_oe_o)
  );
endmodule

// File: rtl/lpm_sequencer_chk.sv
module lpm_sequencer_chk #(
  parameter int HALF_W = 16
) (
  input logic              clk_i,
  input logic              rst_sync_n,
  input logic [1:0]        mode_o,
  input logic              cpu_clk_en_o,
  input logic              per_clk_en_o,
  input logic              wdt_en_o,
  input logic              instr_done_i,
  input logic              req_idle_i,
  input logic              req_pdown_i,
  input logic [HALF_W-1:0] op_first_i,
  input logic [HALF_W-1:0] op_second_i,
  input logic              nmi_ni,
  input logic              irq_pend_i,
  input logic              prot_fault_o,
  input logic              wr_n_o,
  input logic              rd_n_o,
  input logic              ad_lo_oe_o
);
  assert_pdown_entry_R2: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (mode_o == 2'b00 && instr_done_i && req_pdown_i && !nmi_ni && op_second_i == ~op_first_i)
      |=> (mode_o == 2'b10));

  assert_pdown_clocks_off_R2: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (mode_o == 2'b10) |-> (!cpu_clk_en_o && !per_clk_en_o && !wdt_en_o));

  assert_nmi_high_noop_R3: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (mode_o == 2'b00 && instr_done_i && req_pdown_i && !req_idle_i && nmi_ni) |=> (mode_o == 2'b00));

  assert_fault_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    prot_fault_o |=> prot_fault_o);

  assert_no_strobe_no_change_R5: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (mode_o == 2'b00 && !instr_done_i) |=> (mode_o == 2'b00));

  assert_pdown_held_R6: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (mode_o == 2'b10) |=> (mode_o == 2'b10));

  assert_idle_clocks_R8: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (mode_o == 2'b01) |-> (!cpu_clk_en_o && per_clk_en_o && wdt_en_o));

  assert_idle_wake_R9: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (mode_o == 2'b01 && (irq_pend_i || !nmi_ni)) |=> (mode_o == 2'b00 && cpu_clk_en_o));

  assert_lowpower_pins_R10: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (mode_o != 2'b00) |-> (wr_n_o && rd_n_o && !ad_lo_oe_o));

  assert_mode_legal_R1: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    mode_o != 2'b11);
endmodule

bind lpm_sequencer lpm_sequencer_chk #(.HALF_W(HALF_W)) u_chk (
  .clk_i        (clk_i),
  .rst_sync_n   (rst_sync_n),
  .mode_o       (mode_o),
  .cpu_clk_en_o (cpu_clk_en_o),
  .per_clk_en_o (per_clk_en_o),
  .wdt_en_o     (wdt_en_o),
  .instr_done_i (instr_done_i),
  .req_idle_i   (req_idle_i),
  .req_pdown_i  (req_pdown_i),
  .op_first_i   (op_first_i),
  .op_second_i  (op_second_i),
  .nmi_ni       (nmi_ni),
  .irq_pend_i   (irq_pend_i),
  .prot_fault_o (prot_fault_o),
  .wr_n_o       (wr_n_o),
  .rd_n_o       (rd_n_o),
  .ad_lo_oe_o   (ad_lo_oe_o)
);

// File: tb/lpm_sequencer_bench.sv
`timescale 1ns/1ps
module lpm_sequencer_bench;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        instr_done_i, req_idle_i, req_pdown_i;
  logic [15:0] op_first_i, op_second_i;
  logic        nmi_ni, irq_pend_i, bus_cyc_i, bhe_n_i, bus_mux8_i;
  logic [7:0]  addr_hi_i, ad_hi_i, ad_lo_i;
  logic        wr_n_i, rd_n_i, ad_hi_oe_i, ad_lo_oe_i;
  logic [1:0]  mode_o;
  logic        cpu_clk_en_o, per_clk_en_o, wdt_en_o, ram_keep_o, prot_fault_o;
  logic        wr_n_o, rd_n_o, bhe_n_o, ad_hi_oe_o, ad_lo_oe_o;
  logic [7:0]  ad_hi_o, ad_lo_o;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  lpm_sequencer u_lpm_sequencer (
    .clk_i(clk), .rst_ni(rst_ni), .instr_done_i(instr_done_i), .req_idle_i(req_idle_i),
    .req_pdown_i(req_pdown_i), .op_first_i(op_first_i), .op_second_i(op_second_i),
    .nmi_ni(nmi_ni), .irq_pend_i(irq_pend_i), .bus_cyc_i(bus_cyc_i), .bhe_n_i(bhe_n_i),
    .addr_hi_i(addr_hi_i), .bus_mux8_i(bus_mux8_i), .wr_n_i(wr_n_i), .rd_n_i(rd_n_i),
    .ad_hi_i(ad_hi_i), .ad_hi_oe_i(ad_hi_oe_i), .ad_lo_i(ad_lo_i), .ad_lo_oe_i(ad_lo_oe_i),
    .mode_o(mode_o), .cpu_clk_en_o(cpu_clk_en_o), .per_clk_en_o(per_clk_en_o),
    .wdt_en_o(wdt_en_o), .ram_keep_o(ram_keep_o), .prot_fault_o(prot_fault_o),
    .wr_n_o(wr_n_o), .rd_n_o(rd_n_o), .bhe_n_o(bhe_n_o), .ad_hi_o(ad_hi_o),
    .ad_hi_oe_o(ad_hi_oe_o), .ad_lo_o(ad_lo_o), .ad_lo_oe_o(ad_lo_oe_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk("R6 reset acts at once, mode", {30'd0, mode_o}, 32'd0);
    chk("R7 ram keep during reset", {31'd0, ram_keep_o}, 32'd1);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic exec_instr(input bit idle, input bit pd, input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    req_idle_i = idle; req_pdown_i = pd; op_first_i = a; op_second_i = b; instr_done_i = 1'b1;
    @(negedge clk);
    req_idle_i = 1'b0; req_pdown_i = 1'b0; instr_done_i = 1'b0;
  endtask

  task automatic t_reset_state();
    chk("R1 mode after reset", {30'd0, mode_o}, 32'd0);
    chk("R1 enables after reset", {29'd0, cpu_clk_en_o, per_clk_en_o, wdt_en_o}, 32'd7);
    chk("R1 fault after reset", {31'd0, prot_fault_o}, 32'd0);
    chk("R7 ram keep in run", {31'd0, ram_keep_o}, 32'd1);
  endtask

  task automatic t_run_passthrough();
    @(negedge clk);
    wr_n_i = 1'b0; rd_n_i = 1'b1; ad_lo_i = 8'h3c; ad_lo_oe_i = 1'b1; ad_hi_i = 8'h81; ad_hi_oe_i = 1'b1;
    #1;
    chk("R12 run write strobe", {31'd0, wr_n_o}, 32'd0);
    chk("R12 run low port", {23'd0, ad_lo_oe_o, ad_lo_o}, {23'd0, 1'b1, 8'h3c});
    chk("R12 run high port", {23'd0, ad_hi_oe_o, ad_hi_o}, {23'd0, 1'b1, 8'h81});
    wr_n_i = 1'b1;
  endtask

  task automatic t_no_strobe();
    @(negedge clk);
    req_pdown_i = 1'b1; nmi_ni = 1'b0; op_first_i = 16'h1234; op_second_i = ~16'h1234;
    @(negedge clk);
    chk("R5 request without strobe", {30'd0, mode_o}, 32'd0);
    req_pdown_i = 1'b0; nmi_ni = 1'b1;
  endtask

  task automatic t_nmi_high();
    nmi_ni = 1'b1;
    exec_instr(1'b0, 1'b1, 16'h5aa5, ~16'h5aa5);
    chk("R3 power-down with NMI high", {30'd0, mode_o}, 32'd0);
    chk("R3 CPU clock kept", {31'd0, cpu_clk_en_o}, 32'd1);
  endtask

  task automatic t_bad_encoding();
    nmi_ni = 1'b0;
    exec_instr(1'b0, 1'b1, 16'h00ff, 16'h00ff);
    chk("R4 broken encoding ignored", {30'd0, mode_o}, 32'd0);
    chk("R4 fault set", {31'd0, prot_fault_o}, 32'd1);
    nmi_ni = 1'b1;
    repeat (4) @(negedge clk);
    chk("R4 fault sticky", {31'd0, prot_fault_o}, 32'd1);
  endtask

  task automatic t_idle_irq();
    @(negedge clk);
    bus_cyc_i = 1'b1; bhe_n_i = 1'b0; addr_hi_i = 8'ha5;
    @(negedge clk);
    bus_cyc_i = 1'b0; bhe_n_i = 1'b1; addr_hi_i = 8'h11; bus_mux8_i = 1'b1;
    wr_n_i = 1'b0; rd_n_i = 1'b0; ad_lo_oe_i = 1'b1;
    exec_instr(1'b1, 1'b0, 16'hc0de, ~16'hc0de);
    chk("R8 idle mode", {30'd0, mode_o}, 32'd1);
    chk("R8 idle enables", {29'd0, cpu_clk_en_o, per_clk_en_o, wdt_en_o}, 32'd3);
    chk("R10 idle strobes and low port", {29'd0, wr_n_o, rd_n_o, ad_lo_oe_o}, 32'd6);
    chk("R11 idle byte-high hold", {31'd0, bhe_n_o}, 32'd0);
    chk("R11 idle high port muxed", {23'd0, ad_hi_oe_o, ad_hi_o}, {23'd0, 1'b1, 8'ha5});
    bus_mux8_i = 1'b0;
    #1;
    chk("R11 idle high port released", {31'd0, ad_hi_oe_o}, 32'd0);
    @(negedge clk);
    chk("R9 idle held without wake", {30'd0, mode_o}, 32'd1);
    irq_pend_i = 1'b1;
    @(negedge clk);
    chk("R9 wake on interrupt", {30'd0, mode_o}, 32'd0);
    chk("R9 CPU clock back", {31'd0, cpu_clk_en_o}, 32'd1);
    irq_pend_i = 1'b0; wr_n_i = 1'b1; rd_n_i = 1'b1; ad_lo_oe_i = 1'b0;
  endtask

  task automatic t_idle_nmi();
    exec_instr(1'b1, 1'b0, 16'h0001, 16'hfffe);
    chk("R8 idle entry again", {30'd0, mode_o}, 32'd1);
    nmi_ni = 1'b0;
    @(negedge clk);
    chk("R9 wake on NMI", {30'd0, mode_o}, 32'd0);
    nmi_ni = 1'b1;
  endtask

  task automatic t_pdown();
    nmi_ni = 1'b0;
    exec_instr(1'b1, 1'b1, 16'hbeef, ~16'hbeef);
    chk("R2 power-down entry over idle", {30'd0, mode_o}, 32'd2);
    chk("R2 all enables off", {29'd0, cpu_clk_en_o, per_clk_en_o, wdt_en_o}, 32'd0);
    chk("R10 power-down pins", {29'd0, wr_n_o, rd_n_o, ad_lo_oe_o}, 32'd6);
    chk("R7 ram keep in power-down", {31'd0, ram_keep_o}, 32'd1);
    nmi_ni = 1'b1;
    @(negedge clk);
    nmi_ni = 1'b0; irq_pend_i = 1'b1;
    repeat (3) @(negedge clk);
    chk("R6 no wake by NMI or interrupt", {30'd0, mode_o}, 32'd2);
    nmi_ni = 1'b1; irq_pend_i = 1'b0;
    do_reset();
    chk("R6 reset leaves power-down", {30'd0, mode_o}, 32'd0);
    chk("R6 reset clears fault", {31'd0, prot_fault_o}, 32'd0);
    chk("R6 enables back", {29'd0, cpu_clk_en_o, per_clk_en_o, wdt_en_o}, 32'd7);
  endtask

  initial begin
    rst_ni = 1'b0; instr_done_i = 1'b0; req_idle_i = 1'b0; req_pdown_i = 1'b0;
    op_first_i = '0; op_second_i = '0; nmi_ni = 1'b1; irq_pend_i = 1'b0;
    bus_cyc_i = 1'b0; bhe_n_i = 1'b1; addr_hi_i = '0; bus_mux8_i = 1'b0;
    wr_n_i = 1'b1; rd_n_i = 1'b1; ad_hi_i = '0; ad_hi_oe_i = 1'b0; ad_lo_i = '0; ad_lo_oe_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    t_reset_state();
    t_run_passthrough();
    t_no_strobe();
    t_nmi_high();
    t_bad_encoding();
    t_idle_irq();
    t_idle_nmi();
    t_pdown();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule